// File: doc/BRIEF.md
# Microframe Index Counter with Rollover Event

This block keeps the running microframe number of a USB host controller. A prescaler turns the system clock into one tick per 125 microsecond microframe. A 14-bit counter advances on each tick and rolls over silently at its top value. Software reads the count through a small register read port at offset 0x00 of the runtime register space.

The block sees every command register write. It keeps the masked command bits. A write that starts the controller, or a write that asks for a controller reset, moves the count back to zero. When the count rolls from 0x3FFF to 0, the block sends a one-cycle event toward the event generator. It does so only if the run bit and the rollover-event enable bit are both set. The event carries a fixed event type and a success completion code. While the controller is halted, the count and the prescaler keep their values.

Top module: `mfindex_ctr`

## Requirements
- R1: After rst_ni is released, the count is 0, cmd_o is 0 and evt_valid_o is low.
- R2: While the run bit (command bit 0) is set, the count goes up by exactly one every CLK_PER_UFRAME clock cycles. It changes in no other way, except for a re-base to zero.
- R3: A read with rd_en_i high and rd_addr_i equal to 0 returns the count in rd_data_o[13:0], with the upper bits zero. Any other address, or rd_en_i low, returns 0.
- R4: After 0x3FFF the count goes to 0.
- R5: A rollover while both the run bit and the enable bit (command bit 10) are set raises evt_valid_o for exactly one cycle. The pulse appears in the same cycle the count becomes 0, with evt_type_o = 8'd39 and evt_code_o = 8'd1.
- R6: With the enable bit clear, a rollover produces no event, and the count still wraps.
- R7: A write that sets the run bit while it was clear re-bases the count and the prescaler to zero.
- R8: While the run bit is clear, the count holds its value.
- R9: A write with command bit 1 set clears the count and the stored command to zero. Bit 1 is not stored. It overrides a run bit set in the same write, so the controller stays halted.
- R10: A command write stores only the bits of mask 0xC0F (less bit 1), and cmd_o shows them.
- R11: If a command write lands in the same cycle as a rollover, the newly written run and enable bits decide whether the event fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command register write data |
| cmd_o | output | 32 | Stored command bits |
| rd_en_i | input | 1 | Runtime register read enable |
| rd_addr_i | input | ADDR_W | Runtime register byte offset |
| rd_data_o | output | 32 | Read data, combinational |
| evt_valid_o | output | 1 | Rollover event pulse |
| evt_type_o | output | 8 | Event type, 39 while the pulse is high |
| evt_code_o | output | 8 | Completion code, 1 while the pulse is high |

## Verification
A command write and the rollover tick can land on the same clock edge. The bench provokes this by counting cycles from a known start. It then issues the write that sets the enable bit so that it lands exactly on the edge where the count leaves 0x3FFF. The scoreboard expects an event at that exact cycle. This shows that the new command value, not the old one, decides whether the event fires. Any event seen at another cycle is counted as a failure.

// File: rtl/mfindex_pkg.sv
package mfindex_pkg;
  localparam int unsigned CMD_W       = 32;
  localparam logic [31:0] CMD_MASK    = 32'h0000_0C0F;
  localparam int unsigned RUN_BIT     = 0;
  localparam int unsigned HCRST_BIT   = 1;
  localparam int unsigned WRAP_EN_BIT = 10;
  localparam logic [7:0]  EVT_UFWRAP  = 8'd39;
  localparam logic [7:0]  CC_SUCCESS  = 8'd1;

  typedef struct packed {
    logic [7:0] ev_type;
    logic [7:0] cc;
  } wrap_evt_t;
endpackage

// File: rtl/mfi_cmd_reg.sv
module mfi_cmd_reg
  import mfindex_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] wdata_i,
  output logic [CMD_W-1:0] cmd_q_o,
  output logic             run_nxt_o,
  output logic             arm_nxt_o,
  output logic             start_o,
  output logic             hc_rst_o
);
  logic [CMD_W-1:0] wr_val, cmd_nxt, cmd_q;

  assign wr_val   = wdata_i & CMD_MASK;
  assign hc_rst_o = we_i & wdata_i[HCRST_BIT];
  // reset bit is self-clearing and wins over run
  always_comb begin
    cmd_nxt = cmd_q;
    if (hc_rst_o)  cmd_nxt = '0;
    else if (we_i) cmd_nxt = wr_val & ~(CMD_W'(1) << HCRST_BIT);
  end

  assign start_o   = we_i & ~hc_rst_o & wr_val[RUN_BIT] & ~cmd_q[RUN_BIT];
  assign run_nxt_o = cmd_nxt[RUN_BIT];
  assign arm_nxt_o = cmd_nxt[RUN_BIT] & cmd_nxt[WRAP_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_nxt;
  end

  assign cmd_q_o = cmd_q;
endmodule

// File: rtl/mfi_prescaler.sv
module mfi_prescaler #(
  parameter int unsigned DIV = 15625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mfi_counter.sv
module mfi_counter #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] idx_o,
  output logic         wrap_o
);
  logic [W-1:0] idx_q;

  assign wrap_o = tick_i & (&idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (tick_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/mfindex_ctr.sv
module mfindex_ctr
  import mfindex_pkg::*;
#(
  parameter int unsigned CLK_PER_UFRAME = 15625,
  parameter int unsigned IDX_W          = 14,
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned REG_OFFSET     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  output logic [CMD_W-1:0]  cmd_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              evt_valid_o,
  output logic [7:0]        evt_type_o,
  output logic [7:0]        evt_code_o
);
  localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(REG_OFFSET);
  localparam wrap_evt_t WRAP_EVT = '{ev_type: EVT_UFWRAP, cc: CC_SUCCESS};

  logic             run_nxt, arm_nxt, start, hc_rst, rebase, run_en;
  logic             tick, wrap, evt_q;
  logic [IDX_W-1:0] idx_q;

  mfi_cmd_reg u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cmd_we_i),
    .wdata_i  (cmd_wdata_i),
    .cmd_q_o  (cmd_o),
    .run_nxt_o(run_nxt),
    .arm_nxt_o(arm_nxt),
    .start_o  (start),
    .hc_rst_o (hc_rst)
  );

  assign rebase = start | hc_rst;
  assign run_en = run_nxt & ~rebase;

  mfi_prescaler #(.DIV(CLK_PER_UFRAME)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rebase),
    .en_i  (run_en),
    .tick_o(tick)
  );

  mfi_counter #(.W(IDX_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rebase),
    .tick_i(tick),
    .idx_o (idx_q),
    .wrap_o(wrap)
  );

  // arming uses the command value written this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= wrap & arm_nxt;
  end

  assign evt_valid_o = evt_q;
  assign evt_type_o  = evt_q ? WRAP_EVT.ev_type : 8'h00;
  assign evt_code_o  = evt_q ? WRAP_EVT.cc : 8'h00;

  generate
    if (DATA_W > IDX_W) begin : g_pad
      assign rd_data_o = (rd_en_i && rd_addr_i == REG_ADDR)
                         ? {{(DATA_W-IDX_W){1'b0}}, idx_q} : '0;
    end else begin : g_nopad
      assign rd_data_o = (rd_en_i && rd_addr_i == REG_ADDR) ? DATA_W'(idx_q) : '0;
    end
  endgenerate
endmodule

// File: rtl/mfindex_ctr_chk.sv
module mfindex_ctr_chk
  import mfindex_pkg::*;
#(
  parameter int unsigned IDX_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_we_i,
  input logic             hc_req_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic [IDX_W-1:0] idx_i,
  input logic             evt_valid_o,
  input logic [7:0]       evt_type_o,
  input logic [7:0]       evt_code_o
);
  localparam logic [IDX_W-1:0] TOP = '1;

  // R5
  evt_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (evt_type_o == EVT_UFWRAP && evt_code_o == CC_SUCCESS && idx_i == '0));
  // R5
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);
  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(idx_i) == TOP && idx_i != TOP) |-> idx_i == '0);
  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i != $past(idx_i)) |-> (idx_i == $past(idx_i) + 1'b1 || idx_i == '0));
  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cmd_o[RUN_BIT]) && $past(!cmd_we_i)) |-> $stable(idx_i));
  // R9
  hc_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_we_i && hc_req_i) |-> (idx_i == '0 && cmd_o == '0));
  // R10
  cmd_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o & ~(CMD_MASK & ~(CMD_W'(1) << HCRST_BIT))) == '0);
endmodule

bind mfindex_ctr mfindex_ctr_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .hc_req_i   (cmd_wdata_i[1]),
  .cmd_o      (cmd_o),
  .idx_i      (idx_q),
  .evt_valid_o(evt_valid_o),
  .evt_type_o (evt_type_o),
  .evt_code_o (evt_code_o)
);

// File: tb/mfindex_ctr_tb_top.sv
`timescale 1ns/1ps
module mfindex_ctr_tb_top;
  localparam int unsigned DIV  = 2;
  localparam int unsigned WRAP = DIV * 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] cmd;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        evt_v;
  logic [7:0]  evt_t, evt_c;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mfindex_ctr #(.CLK_PER_UFRAME(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wdata), .cmd_o(cmd),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_valid_o(evt_v), .evt_type_o(evt_t), .evt_code_o(evt_c)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr_now(input logic [31:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_now(v);
  endtask

  task automatic rd(input logic en, input logic [5:0] a, output logic [31:0] d);
    rd_en = en; rd_addr = a;
    #1 d = rd_data;
    rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_idx(input int start);
    return 32'(((cyc - start) / DIV) & 14'h3fff);
  endfunction

  // monitor: pops expected event cycles
  always @(negedge clk) begin
    if (rst_n && evt_v) begin
      if (exp_q.size() == 0) begin
        chk("R5/R6 unexpected event", 32'(cyc), 32'hffff_ffff);
      end else begin
        chk("R5 event cycle", 32'(cyc), 32'(exp_q.pop_front()));
        chk("R5 event type", {24'h0, evt_t}, 32'd39);
        chk("R5 event code", {24'h0, evt_c}, 32'd1);
      end
    end
  end

  initial begin
    while (!done && cyc < 200000) @(negedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    int p0, p2, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b1, 6'd0, d);
    chk("R1 count", d, 32'd0);
    chk("R1 cmd", cmd, 32'd0);
    chk("R1 evt", {31'd0, evt_v}, 32'd0);

    // R10 + R7 start, wrap events enabled
    wr(32'hffff_fffd);
    p0 = cyc;
    chk("R10 masked cmd", cmd, 32'h0000_0c0d);
    exp_q.push_back(p0 + WRAP);
    wait_to(p0 + 11);
    rd(1'b1, 6'd0, d);
    chk("R2 count", d, exp_idx(p0));
    rd(1'b1, 6'd4, d);
    chk("R3 other offset", d, 32'd0);
    rd(1'b0, 6'd0, d);
    chk("R3 no enable", d, 32'd0);
    wait_to(p0 + 4001);
    rd(1'b1, 6'd0, d);
    chk("R2 count later", d, exp_idx(p0));
    wait_to(p0 + WRAP + 3);
    rd(1'b1, 6'd0, d);
    chk("R4 after wrap", d, 32'd1);
    chk("R5 event consumed", 32'(exp_q.size()), 32'd0);

    // R8 halt
    wr(32'h0000_0c00);
    rd(1'b1, 6'd0, held);
    repeat (20) @(negedge clk);
    rd(1'b1, 6'd0, d);
    chk("R8 held", d, held);

    // R7 restart without wrap enable; R6 first wrap silent
    wr(32'h0000_0001);
    p2 = cyc;
    wait_to(p2 + 6);
    rd(1'b1, 6'd0, d);
    chk("R7 rebased", d, 32'd3);
    wait_to(p2 + WRAP + 5);
    rd(1'b1, 6'd0, d);
    chk("R6 wrapped silently", d, 32'd2);

    // R11 enable written on the wrap edge
    t2 = p2 + 2 * WRAP;
    exp_q.push_back(t2);
    wait_to(t2 - 1);
    wr_now(32'h0000_0401);
    wait_to(t2 + 2);
    chk("R11 event taken", 32'(exp_q.size()), 32'd0);

    // R9 reset with run
    wr(32'h0000_0003);
    chk("R9 cmd cleared", cmd, 32'd0);
    rd(1'b1, 6'd0, d);
    chk("R9 count zero", d, 32'd0);
    repeat (10) @(negedge clk);
    rd(1'b1, 6'd0, d);
    chk("R9 stays halted", d, 32'd0);

    repeat (4) @(negedge clk);
    chk("R5 no pending events", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule